// File: doc/BRIEF.md
# Left-Shift Serial/Parallel Conversion Register

This block is a four-stage register that moves its contents toward the most significant end, one place per clock, and never the other way. Data enters either one bit per clock on a serial line, into the least significant stage, or as a whole word on parallel inputs. It leaves either as the parallel word or as a serial stream taken from the most significant stage. The same hardware therefore turns a serial stream into a word, turns a word into a stream, or scales a held value up by powers of two.

A parallel load can only turn stages on. A 0 on a parallel input leaves its stage as it was, so software must issue a clear before each new word. The usual sequence is clear, then load or four serial shifts, then read, then clear again. The serial output is the most significant stage gated by the high phase of the clock, so a 1 shows on the line only while the clock is high.

An overflow state machine watches the top stage. It starts in `OVF_CLEAN` after a clear. The transition *lose-bit* moves it to `OVF_LOST` when a shift pushes a 1 out of the top stage. The transition *wipe* returns it to `OVF_CLEAN`, and only a clear takes it. In every other case the machine stays where it is, including a *hold* while in `OVF_LOST`.

Top module: `lshift_conv_reg`

## Requirements
- R1: A high `clr` at a clock edge sets `par_out` to 0 and `ovf` to 0 after that edge, whatever the other inputs are.
- R2: A load (with `load` high and `clr` low) sets `par_out` to the previous `par_out` OR `par_in`, so a 0 bit in `par_in` leaves its stage unchanged.
- R3: A shift (with `shift` high and `clr` and `load` low) sets `par_out` to {previous `par_out`[2:0], `ser_in`}, so after a clear and four shifts the first serial bit sits in bit 3.
- R4: `ser_out` equals `par_out`[3] while `clk` is high and is 0 while `clk` is low.
- R5: Priority within a clock is clear, then load, then shift. With `load` and `shift` both high, only the load takes place.
- R6: `ovf` goes to 1 after a shift in which `par_out`[3] was 1. It stays at 1 through loads, shifts and holds until a clear.
- R7: A shift with `ser_in` at 0 doubles the held value modulo 16. For example 3 becomes 6 and then 12.
- R8: For parallel-to-serial conversion, the sequence is a clear, then a load, then four shifts. After the load the serial line presents bit 3. The next three shifts present bits 2, 1 and 0. The fourth shift leaves `par_out` at 0.
- R9: With `clr`, `load` and `shift` all low, `par_out` and `ovf` keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; its high phase also qualifies the serial output |
| clr | input | 1 | Synchronous active-high clear of all stages and of overflow |
| load | input | 1 | Single-cycle parallel load enable (set-only) |
| par_in | input | 4 | Parallel data; each 1 sets its stage |
| shift | input | 1 | Single-cycle left-shift enable |
| ser_in | input | 1 | Serial data entering the least significant stage |
| par_out | output | 4 | Current stage contents |
| ser_out | output | 1 | Most significant stage ANDed with the clock high phase |
| ovf | output | 1 | A 1 has been shifted out of the top stage since the last clear |

## Verification
All stage state is visible on `par_out` in the cycle after each edge. A wrong stage value or a wrong priority decision therefore shows up at the very next high-phase sample, and the reference model compares against it every clock. A stuck or missed overflow transition shows on `ovf` one edge after the shift that should have caused it. It then stays visible, because the state is sticky. A wrong gating of the serial line shows within half a clock, because the bench samples `ser_out` in both clock phases of every cycle.

// File: rtl/lsc_pkg.sv
`timescale 1ns/1ps
package lsc_pkg;
    // Operation chosen for a clock edge, after priority resolution.
    typedef enum logic [1:0] {
        OP_HOLD  = 2'd0,
        OP_SHIFT = 2'd1,
        OP_LOAD  = 2'd2,
        OP_CLEAR = 2'd3
    } lsc_op_e;

    // Overflow tracking states.
    typedef enum logic {
        OVF_CLEAN = 1'b0,
        OVF_LOST  = 1'b1
    } lsc_ovf_e;
endpackage

// File: rtl/lsc_op_decode.sv
`timescale 1ns/1ps
module lsc_op_decode
    import lsc_pkg::*;
(
    input  logic    clr,
    input  logic    load,
    input  logic    shift,
    output lsc_op_e op
);
    // Clear outranks load, load outranks shift (R5).
    always_comb begin
        if (clr)        op = OP_CLEAR;
        else if (load)  op = OP_LOAD;
        else if (shift) op = OP_SHIFT;
        else            op = OP_HOLD;
    end
endmodule

// File: rtl/lsc_stage_array.sv
`timescale 1ns/1ps
module lsc_stage_array
    import lsc_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             clr,
    input  logic             load,
    input  logic             shift,
    input  lsc_op_e          op,
    input  logic [WIDTH-1:0] par_in,
    input  logic             ser_in,
    output logic [WIDTH-1:0] q
);
    for (genvar i = 0; i < WIDTH; i++) begin : g_stage
        logic from_right;
        logic stage_q;

        if (i == 0) begin : g_lsb
            assign from_right = ser_in;
        end else begin : g_upper
            assign from_right = q[i-1];
        end

        always_ff @(posedge clk) begin
            unique case (op)
                OP_CLEAR: stage_q <= 1'b0;
                OP_LOAD:  stage_q <= stage_q | par_in[i];
                OP_SHIFT: stage_q <= from_right;
                default:  stage_q <= stage_q;
            endcase
        end

        assign q[i] = stage_q;
    end

    // R1: clear empties every stage on the next edge.
    assert_clear_empties_R1: assert property (@(posedge clk)
        clr |=> (q == '0));

    // R2: a load ORs into the previous contents.
    assert_load_or_R2: assert property (@(posedge clk) disable iff (clr)
        ($past(load) && !$past(clr)) |-> (q == ($past(q) | $past(par_in))));

    // R3: a shift moves every bit one place up and takes ser_in at the bottom.
    assert_shift_left_R3: assert property (@(posedge clk) disable iff (clr)
        ($past(shift) && !$past(load) && !$past(clr))
            |-> (q == {$past(q[WIDTH-2:0]), $past(ser_in)}));

    // R5: with load and shift together the contents follow the load alone.
    assert_load_beats_shift_R5: assert property (@(posedge clk) disable iff (clr)
        ($past(load) && $past(shift) && !$past(clr))
            |-> (q == ($past(q) | $past(par_in))));

    // R9: no enable means no change.
    assert_idle_holds_R9: assert property (@(posedge clk) disable iff (clr)
        (!$past(clr) && !$past(load) && !$past(shift)) |-> $stable(q));
endmodule

// File: rtl/lsc_ovf_fsm.sv
`timescale 1ns/1ps
module lsc_ovf_fsm
    import lsc_pkg::*;
(
    input  logic    clk,
    input  logic    clr,
    input  lsc_op_e op,
    input  logic    top_bit,
    output logic    ovf
);
    lsc_ovf_e state_q;
    lsc_ovf_e state_d;

    // Next-state logic: lose-bit, wipe, hold.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            OVF_CLEAN: begin
                if (op == OP_CLEAR)                 state_d = OVF_CLEAN;
                else if (op == OP_SHIFT && top_bit) state_d = OVF_LOST;
            end
            OVF_LOST: begin
                if (op == OP_CLEAR)                 state_d = OVF_CLEAN;
            end
            default:                                state_d = OVF_CLEAN;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        state_q <= state_d;
    end

    // Outputs.
    always_comb begin
        ovf = (state_q == OVF_LOST);
    end

    // R6: shifting out a 1 raises the flag.
    assert_lose_bit_R6: assert property (@(posedge clk) disable iff (clr)
        (op == OP_SHIFT && top_bit) |=> ovf);

    // R6: the flag is sticky until a clear.
    assert_flag_sticky_R6: assert property (@(posedge clk) disable iff (clr)
        ovf |=> ovf);

    // R1: a clear drops the flag.
    assert_wipe_clears_R1: assert property (@(posedge clk)
        clr |=> !ovf);
endmodule

// File: rtl/lshift_conv_reg.sv
`timescale 1ns/1ps
module lshift_conv_reg
    import lsc_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             clr,
    input  logic             load,
    input  logic [WIDTH-1:0] par_in,
    input  logic             shift,
    input  logic             ser_in,
    output logic [WIDTH-1:0] par_out,
    output logic             ser_out,
    output logic             ovf
);
    localparam int TOP = WIDTH - 1;

    lsc_op_e          op;
    logic [WIDTH-1:0] stages;

    lsc_op_decode u_decode (
        .clr   (clr),
        .load  (load),
        .shift (shift),
        .op    (op)
    );

    lsc_stage_array #(.WIDTH(WIDTH)) u_stages (
        .clk    (clk),
        .clr    (clr),
        .load   (load),
        .shift  (shift),
        .op     (op),
        .par_in (par_in),
        .ser_in (ser_in),
        .q      (stages)
    );

    lsc_ovf_fsm u_ovf (
        .clk     (clk),
        .clr     (clr),
        .op      (op),
        .top_bit (stages[TOP]),
        .ovf     (ovf)
    );

    assign par_out = stages;
    // The top stage reaches the line only during the clock high phase.
    assign ser_out = stages[TOP] & clk;
endmodule

// File: tb/lshift_conv_reg_test.sv
`timescale 1ns/1ps
module lshift_conv_reg_test;
    localparam int W = 4;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic         clr = 1'b0, load = 1'b0, shift = 1'b0, sin = 1'b0;
    logic [W-1:0] pin = '0;
    logic [W-1:0] pout;
    logic         sout, ovf;

    lshift_conv_reg #(.WIDTH(W)) uut (
        .clk(clk), .clr(clr), .load(load), .par_in(pin), .shift(shift),
        .ser_in(sin), .par_out(pout), .ser_out(sout), .ovf(ovf)
    );

    int tests = 0;
    int fails = 0;
    int model_q = 0;
    int model_ovf = 0;
    int last_sout = 0;

    task automatic chk(input string tag, input string what, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    // Drive one operation during the low phase, apply it, and compare in both phases.
    task automatic step(input bit c, input bit l, input bit s, input int p,
                        input bit si, input string tag);
        clr = c; load = l; shift = s; pin = p[W-1:0]; sin = si;
        @(posedge clk);
        if (c) begin
            model_q = 0; model_ovf = 0;
        end else if (l) begin
            model_q = model_q | p;
        end else if (s) begin
            if (((model_q >> 3) & 1) == 1) model_ovf = 1;
            model_q = ((model_q << 1) | int'(si)) & 15;
        end
        #1;
        chk(tag, "par_out", int'(pout), model_q);
        chk(tag, "ovf", int'(ovf), model_ovf);
        chk("R4", "ser_out high phase", int'(sout), (model_q >> 3) & 1);
        last_sout = int'(sout);
        @(negedge clk);
        #0.5;
        chk("R4", "ser_out low phase", int'(sout), 0);
    endtask

    task automatic p2s(input int word);
        int got = 0;
        step(1, 0, 0, 0, 0, "R1");
        step(0, 1, 0, word, 0, "R8");
        got = last_sout;
        for (int k = 0; k < 3; k++) begin
            step(0, 0, 1, 0, 0, "R8");
            got = (got << 1) | last_sout;
        end
        chk("R8", "serial word", got, word);
        step(0, 0, 1, 0, 0, "R8");
        chk("R8", "emptied", int'(pout), 0);
    endtask

    task automatic s2p(input int word);
        step(1, 0, 0, 0, 0, "R1");
        for (int k = 3; k >= 0; k--) step(0, 0, 1, 0, bit'((word >> k) & 1), "R3");
        chk("R3", "parallel word", int'(pout), word);
    endtask

    initial begin
        @(negedge clk);
        #0.5;
        // Reset state
        step(1, 1, 1, 15, 1, "R1");
        chk("R1", "reset par_out", int'(pout), 0);
        chk("R1", "reset ovf", int'(ovf), 0);

        // Round trips
        p2s(4'b0101);
        p2s(4'b1110);
        s2p(4'b0101);
        s2p(4'b1110);

        // Set-only load without clear
        step(1, 0, 0, 0, 0, "R1");
        step(0, 1, 0, 4'b1001, 0, "R2");
        step(0, 1, 0, 4'b0110, 0, "R2");
        chk("R2", "or load", int'(pout), 15);
        step(0, 1, 0, 4'b0000, 0, "R2");
        chk("R2", "zero load no effect", int'(pout), 15);

        // Priority
        step(1, 1, 1, 4'b1111, 1, "R5");
        chk("R5", "clear wins", int'(pout), 0);
        step(0, 1, 1, 4'b0010, 1, "R5");
        chk("R5", "load beats shift", int'(pout), 2);

        // Scaling and overflow
        step(1, 0, 0, 0, 0, "R1");
        step(0, 1, 0, 3, 0, "R7");
        step(0, 0, 1, 0, 0, "R7");
        chk("R7", "x2", int'(pout), 6);
        step(0, 0, 1, 0, 0, "R7");
        chk("R7", "x4", int'(pout), 12);
        chk("R6", "no overflow yet", int'(ovf), 0);
        step(0, 0, 1, 0, 0, "R6");
        chk("R6", "overflow raised", int'(ovf), 1);
        step(0, 1, 0, 0, 0, "R6");
        step(0, 0, 0, 0, 0, "R9");
        step(0, 0, 1, 0, 0, "R6");
        chk("R6", "overflow sticky", int'(ovf), 1);

        // Hold
        step(0, 1, 0, 4'b0101, 0, "R9");
        for (int k = 0; k < 3; k++) step(0, 0, 0, 4'b1010, 1, "R9");
        chk("R9", "held value", int'(pout), 5);
        step(1, 0, 0, 0, 0, "R1");
        chk("R1", "clear drops ovf", int'(ovf), 0);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        #100000;
        fails++;
        tests++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule